// File: doc/BRIEF.md
# Region Storage Attribute Lookup Unit

This block holds two 32-bit attribute registers. One is the write-through register and the other is the cacheability register. Together they divide the 4 GB physical address space into 32 regions of 128 MB each. Every access presents a 32-bit address and a flag that tells an instruction fetch from a data access. The unit answers in the same cycle with the write-through and cacheable attributes of the region that holds that address.

Software loads either register through a small port. The port has a one-bit register select, a write strobe and 32-bit write and read buses.

The region numbering runs from the most significant bit downwards. Register bit 0 in that numbering, which is the MSB of the stored word, covers the lowest 128 MB. Write-through has meaning only for data accesses. A data region marked write-through but not cacheable is a model the system does not support. The unit raises an error flag for it and withholds write-through.

Top module: `region_attr_lookup`

## Requirements
- R1: After reset both registers read 0. Every lookup then returns lk_wthru=0, lk_cache=0 and lk_err=0: write-back and caching inhibited everywhere.
- R2: A write with reg_we=1 stores reg_wdata at the next rising clock edge. The register it goes to is the write-through register when reg_sel=0 and the cacheability register when reg_sel=1. reg_rdata returns the stored word of the register that reg_sel selects, unchanged.
- R3: The region index is lk_addr[31:27]. Region k is governed by stored bit 31−k. So the stored MSB (bit 31) covers 0x0000_0000–0x07FF_FFFF and the stored LSB (bit 0) covers 0xF800_0000–0xFFFF_FFFF.
- R4: A data lookup (lk_instr=0) in a region whose cacheable bit is 1 drives lk_wthru with that region's write-through bit. A 1 means write-through and a 0 means write-back.
- R5: An instruction lookup (lk_instr=1) always drives lk_wthru=0 and lk_err=0, whatever the register contents.
- R6: A data lookup in a region whose write-through bit is 1 and whose cacheable bit is 0 drives lk_err=1 and lk_wthru=0. lk_err is 0 in every other case.
- R7: lk_cache equals the cacheable bit of the addressed region for both instruction and data lookups.
- R8: A cycle with reg_we=0 leaves both registers unchanged, whatever reg_sel and reg_wdata carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | 0 selects the write-through register, 1 selects the cacheability register |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Contents of the selected register |
| lk_addr | input | 32 | Lookup address |
| lk_instr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| lk_wthru | output | 1 | Write-through attribute of the addressed region |
| lk_cache | output | 1 | Cacheable attribute of the addressed region |
| lk_err | output | 1 | Unsupported write-through with caching inhibited |

## Verification
The bench sweeps all 32 regions with asymmetric bit patterns and probes both ends of each extreme region. A decoder that numbered the bits LSB-first, or that took the wrong address slice, would return mirrored or shifted attributes. It repeats each sweep with instruction fetches, which exposes a design that leaks write-through or the error flag onto the fetch side. Regions set write-through but not cacheable catch a design that misses the error or lets write-through through alongside it. Strobe-low cycles with live data and select catch a register that loads without its write enable.

// File: rtl/region_attr_lookup.sv
module region_attr_lookup #(
  parameter int AW = 32,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_we,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_instr,
  output logic          lk_wthru,
  output logic          lk_cache,
  output logic          lk_err
);
  localparam int IW = $clog2(RW);

  logic [RW-1:0] wt_q, ca_q;

  wire [IW-1:0] idx = lk_addr[AW-1 -: IW];
  wire [IW-1:0] pos = IW'(RW - 1) - idx;
  wire unused_low = ^lk_addr[AW-IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt_q <= '0;
      ca_q <= '0;
    end else if (reg_we) begin
      if (reg_sel) ca_q <= reg_wdata;
      else         wt_q <= reg_wdata;
    end
  end

  wire wt_bit = wt_q[pos];
  wire ca_bit = ca_q[pos];

  assign reg_rdata = reg_sel ? ca_q : wt_q;
  assign lk_cache  = ca_bit;
  assign lk_err    = !lk_instr && wt_bit && !ca_bit;
  assign lk_wthru  = !lk_instr && wt_bit && ca_bit;

  assert_instr_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_instr |-> (!lk_wthru && !lk_err));

  assert_err_no_wt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_err |-> (!lk_wthru && !lk_cache && !lk_instr));

  assert_wt_needs_cache_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_wthru |-> lk_cache);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel) |=> (ca_q == $past(reg_wdata) && $stable(wt_q)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(wt_q) && $stable(ca_q)));

endmodule

// File: tb/region_attr_lookup_test.sv
`timescale 1ns/1ps
module region_attr_lookup_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_sel = 0, reg_we = 0, lk_instr = 0;
  logic [31:0] reg_wdata = 0, lk_addr = 0;
  logic [31:0] reg_rdata;
  logic        lk_wthru, lk_cache, lk_err;

  region_attr_lookup uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_instr(lk_instr), .lk_wthru(lk_wthru), .lk_cache(lk_cache), .lk_err(lk_err)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] rdata;
    logic        wthru;
    logic        cache;
    logic        err;
    logic [7:0]  req;
  } item_t;

  item_t       sbq[$];
  int          checks = 0, errors = 0;
  bit          finished = 0;
  logic [31:0] wt_m = 0, ca_m = 0;

  task automatic probe(input logic sel, input logic [31:0] addr,
                       input logic instr, input logic [7:0] req);
    item_t it;
    int k;
    logic w, c;
    @(negedge clk);
    reg_sel = sel; lk_addr = addr; lk_instr = instr; reg_we = 0;
    k = int'(addr[31:27]);
    w = wt_m[31-k];
    c = ca_m[31-k];
    it.rdata = sel ? ca_m : wt_m;
    it.cache = c;
    it.wthru = !instr && w && c;
    it.err   = !instr && w && !c;
    it.req   = req;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic sel, input logic [31:0] data, input logic we);
    @(negedge clk);
    reg_sel = sel; reg_wdata = data; reg_we = we;
    @(posedge clk);
    if (we) begin
      if (sel) ca_m = data; else wt_m = data;
    end
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic report(input int req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
    errors++;
    $display("FAIL R%0d %s actual=%h expected=%h addr=%h instr=%b",
             req, what, act, exp, lk_addr, lk_instr);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        checks++;
        if (reg_rdata !== it.rdata)    report(int'(it.req), "rdata", reg_rdata, it.rdata);
        else if (lk_wthru !== it.wthru) report(int'(it.req), "wthru", 32'(lk_wthru), 32'(it.wthru));
        else if (lk_cache !== it.cache) report(int'(it.req), "cache", 32'(lk_cache), 32'(it.cache));
        else if (lk_err !== it.err)     report(int'(it.req), "err", 32'(lk_err), 32'(it.err));
      end
    end
  end

  task automatic direct(input int req, input logic exp_w, input logic exp_c, input logic exp_e);
    #1;
    checks++;
    if (lk_wthru !== exp_w || lk_cache !== exp_c || lk_err !== exp_e) begin
      errors++;
      $display("FAIL R%0d direct actual=%b%b%b expected=%b%b%b addr=%h", req,
               lk_wthru, lk_cache, lk_err, exp_w, exp_c, exp_e, lk_addr);
    end
  endtask

  task automatic sweep(input logic [7:0] req);
    for (int k = 0; k < 32; k++) begin
      probe(1'b0, {5'(k), 27'h2AB_CDE1}, 1'b0, req);
      probe(1'b1, {5'(k), 27'h000_0000}, 1'b1, 8'd5);
    end
  endtask

  initial begin : driver
    #7 rst_n = 1;
    // R1: reset state
    probe(1'b0, 32'h0000_0000, 1'b0, 8'd1);
    probe(1'b1, 32'hFFFF_FFFF, 1'b0, 8'd1);
    probe(1'b0, 32'h8000_0000, 1'b1, 8'd1);
    // R2: writes and readback
    wr(1'b0, 32'h8000_0001, 1'b1);
    wr(1'b1, 32'hFFFF_FFFF, 1'b1);
    probe(1'b0, 32'h1234_5678, 1'b0, 8'd2);
    probe(1'b1, 32'h1234_5678, 1'b0, 8'd2);
    // R3: region edges, stored MSB = lowest region, explicit values
    @(negedge clk); reg_sel = 0; lk_instr = 0; lk_addr = 32'h0000_0000; direct(3, 1, 1, 0);
    @(negedge clk); lk_addr = 32'h07FF_FFFF; direct(3, 1, 1, 0);
    @(negedge clk); lk_addr = 32'h0800_0000; direct(3, 0, 1, 0);
    @(negedge clk); lk_addr = 32'hF7FF_FFFF; direct(3, 0, 1, 0);
    @(negedge clk); lk_addr = 32'hF800_0000; direct(3, 1, 1, 0);
    @(negedge clk); lk_addr = 32'hFFFF_FFFF; direct(3, 1, 1, 0);
    // R5: fetch side never write-through
    @(negedge clk); lk_instr = 1; lk_addr = 32'h0000_0000; direct(5, 0, 1, 0);
    // R4 and R7: asymmetric pattern sweep, cacheable everywhere
    wr(1'b0, 32'hA5C3_0F96, 1'b1);
    sweep(8'd4);
    // R6: mixed cacheability gives error regions
    wr(1'b1, 32'h3C5A_F00F, 1'b1);
    sweep(8'd6);
    // R6 explicit: region 0 write-through, inhibited
    wr(1'b1, 32'h7FFF_FFFF, 1'b1);
    wr(1'b0, 32'h8000_0000, 1'b1);
    @(negedge clk); lk_instr = 0; lk_addr = 32'h0100_0000; direct(6, 0, 0, 1);
    @(negedge clk); lk_instr = 1; direct(5, 0, 0, 0);
    @(negedge clk); lk_instr = 0; lk_addr = 32'h0900_0000; direct(7, 0, 1, 0);
    // R8: strobe low with live data on both selects
    wr(1'b0, 32'h0F0F_1234, 1'b0);
    wr(1'b1, 32'h0000_0000, 1'b0);
    probe(1'b0, 32'h0000_0000, 1'b0, 8'd8);
    probe(1'b1, 32'h0000_0000, 1'b0, 8'd8);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : watchdog
    #200000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule